// File: doc/BRIEF.md
# Fetch Miss Stall Controller

This controller sits beside an instruction fetch unit and decides, cycle by cycle, whether the access presented this cycle may be accepted into the fetch queue. The translation buffer and instruction cache are outside the block. Only their outcome is an input: a two-bit status (known latency, unknown latency, retry) and a latency value for each. From these the controller keeps a blocked flag, for a miss whose latency is not yet known, and a delay countdown, for a miss whose latency is known. A completion callback from the memory system supplies the latency once it is known and releases the block.

The controller also groups consecutive accepted fetches and ends a group early when a stop condition arises. The stop conditions are: a fetch that leaves the current cache line while multi-line fetch is off, reaching the taken-branch limit, reaching the fetch width, a pending unknown branch target, and a pending trap or system call. A front-end recovery clears the unknown-target flag and restarts the group. The outputs are a fetch-enable and a two-bit stall-reason code.

Top module: `fetch_miss_stall`

## Requirements
- R1: After reset the block is neither blocked nor counting down and has no pending unknown target. With no access presented, fetchEn is 0 and stallReason is 0 (none). The first hit access after reset is accepted.
- R2: A translation access is a miss when tlbLat > 1 or tlbStatus is not 0 (0 = known, 1 = unknown, 2 or 3 = retry). A miss with known latency stalls that cycle with stallReason 1 (miss), loads the countdown with tlbLat − 1 and ends the group.
- R3: The cache outcome is looked at only when the translation access hits. A cache access is a miss when icLat > IC_HIT_LAT or icStatus is not 0. A known-latency cache miss stalls with reason 1 and loads the countdown with icLat − 1.
- R4: A miss with status 1 (unknown) sets the blocked flag. While the flag is set, every cycle stalls with reason 1 until a callback arrives.
- R5: A miss with status 2 or 3 (retry) stalls only the current cycle with reason 1. It leaves the blocked flag and the countdown unchanged, so the next hit access is accepted.
- R6: A callback (cbValid) clears the blocked flag and loads the countdown with cbLat. Fetch then stalls for cbLat cycles after the callback cycle, and the callback overrides any other countdown or block update in the same cycle.
- R7: While the countdown is nonzero and the block is not set, it decrements by one per cycle and fetch stalls with reason 1.
- R8: An access that is not the first of its group, with sameLineHit low and multiLineEn low, is refused with stallReason 2 (line end), and the group restarts. With multiLineEn high no line-end stop occurs.
- R9: Once FETCH_SPEED taken branches have been accepted in a group, the next cycle stops with stallReason 3 (group stop) and the group restarts.
- R10: An accepted access with unkTgtIn high sets an unknown-target flag. The flag stops every later cycle with reason 3. A recovery clears the flag in that same cycle, so that cycle is not stopped by it, and it restarts the group.
- R11: A pending trap or system call stops the cycle with reason 3 whenever no block or countdown is active.
- R12: Once FETCH_WIDTH accesses have been accepted in a group, the next cycle stops with reason 3 and the group restarts.
- R13: The priority is block, then countdown, then group stop, then line end, then translation, then cache. fetchEn is 1 only for an access that clears all of them, and then stallReason is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | A fetch access outcome is presented this cycle |
| tlbStatus | input | 2 | Translation status: 0 known, 1 unknown, 2/3 retry |
| tlbLat | input | LAT_W | Translation latency |
| icStatus | input | 2 | Cache status, same coding |
| icLat | input | LAT_W | Cache latency |
| sameLineHit | input | 1 | Access is a fast hit in the current cache line |
| multiLineEn | input | 1 | Allow a group to cross cache lines |
| takenBr | input | 1 | Presented access is a taken branch |
| unkTgtIn | input | 1 | Presented access has an unknown target |
| recover | input | 1 | Front-end recovery this cycle |
| trapPend | input | 1 | Trap waiting to commit |
| syscallPend | input | 1 | System call waiting to commit |
| cbValid | input | 1 | Memory completion callback |
| cbLat | input | LAT_W | Latency supplied by the callback |
| fetchEn | output | 1 | Access accepted this cycle |
| stallReason | output | 2 | 0 none, 1 miss, 2 line end, 3 group stop |

## Verification
The assertions assume that a callback arrives only while the block is set, and that the latency on a known miss is what the status claims, so a countdown is never loaded while another is running. The random stimulus follows the same rule. It raises cbValid only when the bench's own model says the block is set, and it keeps latencies and cbLat small so that countdowns end well inside the run. Directed sequences cover each stop condition, retry and callback path, and random cycles then mix all inputs with low rates of misses, traps and recoveries.

// File: rtl/fms_pkg.sv
package fms_pkg;
  localparam logic [1:0] ST_KNOWN   = 2'd0;
  localparam logic [1:0] ST_UNKNOWN = 2'd1;

  typedef enum logic [1:0] {
    RSN_NONE = 2'd0,
    RSN_MISS = 2'd1,
    RSN_LINE = 2'd2,
    RSN_STOP = 2'd3
  } reason_e;

  typedef struct packed {
    logic setBlock;
    logic loadTlb;
    logic loadIc;
    logic decDelay;
    logic grpReset;
    logic grpAdvance;
  } ctrlStrobe_t;
endpackage

// File: rtl/fms_datapath.sv
module fms_datapath
  import fms_pkg::*;
#(
  parameter int LAT_W       = 6,
  parameter int FETCH_SPEED = 2,
  parameter int FETCH_WIDTH = 4,
  localparam int BR_W   = $clog2(FETCH_SPEED + 1),
  localparam int SLOT_W = $clog2(FETCH_WIDTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [LAT_W-1:0]  tlbLat,
  input  logic [LAT_W-1:0]  icLat,
  input  logic              cbValid,
  input  logic [LAT_W-1:0]  cbLat,
  input  logic              recover,
  input  logic              takenBr,
  input  logic              unkTgtIn,
  output logic              blocked,
  output logic              delayNz,
  output logic              unkTgt,
  output logic [SLOT_W-1:0] slotCnt,
  output logic [BR_W-1:0]   brCnt
);
  logic [LAT_W-1:0] delayCnt;

  assign delayNz = (delayCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blocked  <= 1'b0;
      delayCnt <= '0;
    end else if (cbValid) begin
      blocked  <= 1'b0;
      delayCnt <= cbLat;
    end else begin
      if (strobe.setBlock) blocked <= 1'b1;
      if (strobe.loadTlb)       delayCnt <= tlbLat - 1'b1;
      else if (strobe.loadIc)   delayCnt <= icLat - 1'b1;
      else if (strobe.decDelay) delayCnt <= delayCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unkTgt  <= 1'b0;
      slotCnt <= '0;
      brCnt   <= '0;
    end else if (recover) begin
      unkTgt  <= 1'b0;
      slotCnt <= '0;
      brCnt   <= '0;
    end else if (strobe.grpReset) begin
      slotCnt <= '0;
      brCnt   <= '0;
    end else if (strobe.grpAdvance) begin
      slotCnt <= slotCnt + 1'b1;
      brCnt   <= brCnt + BR_W'(takenBr);
      if (unkTgtIn) unkTgt <= 1'b1;
    end
  end

  assert_unknown_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setBlock && !cbValid) |=> blocked);

  assert_callback_loads_R6: assert property (@(posedge clk) disable iff (!rstN)
    cbValid |=> (!blocked && delayCnt == $past(cbLat)));

  assert_countdown_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decDelay && !cbValid) |=> (delayCnt == $past(delayCnt) - 1'b1));

  assert_retry_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!cbValid && !strobe.setBlock && !strobe.loadTlb && !strobe.loadIc && !strobe.decDelay)
      |=> ($stable(blocked) && $stable(delayCnt)));

  assert_branch_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    brCnt <= BR_W'(FETCH_SPEED));

  assert_recover_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    recover |=> (!unkTgt && slotCnt == '0 && brCnt == '0));
endmodule

// File: rtl/fms_ctrl.sv
module fms_ctrl
  import fms_pkg::*;
#(
  parameter int LAT_W       = 6,
  parameter int FETCH_SPEED = 2,
  parameter int FETCH_WIDTH = 4,
  parameter int IC_HIT_LAT  = 1,
  localparam int BR_W   = $clog2(FETCH_SPEED + 1),
  localparam int SLOT_W = $clog2(FETCH_WIDTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [1:0]        tlbStatus,
  input  logic [LAT_W-1:0]  tlbLat,
  input  logic [1:0]        icStatus,
  input  logic [LAT_W-1:0]  icLat,
  input  logic              sameLineHit,
  input  logic              multiLineEn,
  input  logic              recover,
  input  logic              trapPend,
  input  logic              syscallPend,
  input  logic              blocked,
  input  logic              delayNz,
  input  logic              unkTgt,
  input  logic [SLOT_W-1:0] slotCnt,
  input  logic [BR_W-1:0]   brCnt,
  output ctrlStrobe_t       strobe,
  output logic              fetchEn,
  output reason_e           stallReason
);
  logic tlbMiss, icMiss, stopNow, lineEnd;

  assign tlbMiss = (tlbLat > LAT_W'(1)) || (tlbStatus != ST_KNOWN);
  assign icMiss  = (icLat > LAT_W'(IC_HIT_LAT)) || (icStatus != ST_KNOWN);
  assign stopNow = (unkTgt && !recover) || trapPend || syscallPend ||
                   (brCnt >= BR_W'(FETCH_SPEED)) || (slotCnt >= SLOT_W'(FETCH_WIDTH));
  assign lineEnd = (slotCnt != '0) && !multiLineEn && !sameLineHit;

  always_comb begin
    strobe      = '0;
    fetchEn     = 1'b0;
    stallReason = RSN_NONE;
    if (blocked) begin
      stallReason = RSN_MISS;
    end else if (delayNz) begin
      stallReason     = RSN_MISS;
      strobe.decDelay = 1'b1;
    end else if (stopNow) begin
      stallReason     = RSN_STOP;
      strobe.grpReset = 1'b1;
    end else if (accValid) begin
      if (lineEnd) begin
        stallReason     = RSN_LINE;
        strobe.grpReset = 1'b1;
      end else if (tlbMiss) begin
        stallReason     = RSN_MISS;
        strobe.grpReset = 1'b1;
        if (tlbStatus == ST_KNOWN)        strobe.loadTlb  = 1'b1;
        else if (tlbStatus == ST_UNKNOWN) strobe.setBlock = 1'b1;
      end else if (icMiss) begin
        stallReason     = RSN_MISS;
        strobe.grpReset = 1'b1;
        if (icStatus == ST_KNOWN)        strobe.loadIc   = 1'b1;
        else if (icStatus == ST_UNKNOWN) strobe.setBlock = 1'b1;
      end else begin
        fetchEn           = 1'b1;
        strobe.grpAdvance = 1'b1;
      end
    end
  end

  assert_blocked_stalls_R4: assert property (@(posedge clk) disable iff (!rstN)
    blocked |-> !fetchEn);

  assert_accept_clean_R13: assert property (@(posedge clk) disable iff (!rstN)
    fetchEn |-> (stallReason == RSN_NONE && accValid));

  assert_pending_stops_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((trapPend || syscallPend) && !blocked && !delayNz) |-> (stallReason == RSN_STOP));

  assert_width_bound_R12: assert property (@(posedge clk) disable iff (!rstN)
    (slotCnt >= SLOT_W'(FETCH_WIDTH)) |-> !fetchEn);
endmodule

// File: rtl/fetch_miss_stall.sv
module fetch_miss_stall
  import fms_pkg::*;
#(
  parameter int LAT_W       = 6,
  parameter int FETCH_SPEED = 2,
  parameter int FETCH_WIDTH = 4,
  parameter int IC_HIT_LAT  = 1,
  localparam int BR_W   = $clog2(FETCH_SPEED + 1),
  localparam int SLOT_W = $clog2(FETCH_WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic [1:0]       tlbStatus,
  input  logic [LAT_W-1:0] tlbLat,
  input  logic [1:0]       icStatus,
  input  logic [LAT_W-1:0] icLat,
  input  logic             sameLineHit,
  input  logic             multiLineEn,
  input  logic             takenBr,
  input  logic             unkTgtIn,
  input  logic             recover,
  input  logic             trapPend,
  input  logic             syscallPend,
  input  logic             cbValid,
  input  logic [LAT_W-1:0] cbLat,
  output logic             fetchEn,
  output logic [1:0]       stallReason
);
  ctrlStrobe_t       strobe;
  reason_e           reason;
  logic              blocked, delayNz, unkTgt;
  logic [SLOT_W-1:0] slotCnt;
  logic [BR_W-1:0]   brCnt;

  fms_ctrl #(
    .LAT_W(LAT_W), .FETCH_SPEED(FETCH_SPEED),
    .FETCH_WIDTH(FETCH_WIDTH), .IC_HIT_LAT(IC_HIT_LAT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid),
    .tlbStatus(tlbStatus), .tlbLat(tlbLat),
    .icStatus(icStatus), .icLat(icLat),
    .sameLineHit(sameLineHit), .multiLineEn(multiLineEn),
    .recover(recover), .trapPend(trapPend), .syscallPend(syscallPend),
    .blocked(blocked), .delayNz(delayNz), .unkTgt(unkTgt),
    .slotCnt(slotCnt), .brCnt(brCnt),
    .strobe(strobe), .fetchEn(fetchEn), .stallReason(reason)
  );

  fms_datapath #(
    .LAT_W(LAT_W), .FETCH_SPEED(FETCH_SPEED), .FETCH_WIDTH(FETCH_WIDTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .tlbLat(tlbLat), .icLat(icLat),
    .cbValid(cbValid), .cbLat(cbLat), .recover(recover),
    .takenBr(takenBr), .unkTgtIn(unkTgtIn),
    .blocked(blocked), .delayNz(delayNz), .unkTgt(unkTgt),
    .slotCnt(slotCnt), .brCnt(brCnt)
  );

  assign stallReason = reason;
endmodule

// File: tb/fetch_miss_stall_tb.sv
module fetch_miss_stall_tb;
  localparam int LAT_W = 6;
  localparam int SPEED = 2;
  localparam int WIDTH = 4;
  localparam int IC_HIT = 1;

  logic clk = 1'b0;
  logic rstN;
  logic accValid, sameLineHit, multiLineEn, takenBr, unkTgtIn;
  logic recover, trapPend, syscallPend, cbValid;
  logic [1:0] tlbStatus, icStatus;
  logic [LAT_W-1:0] tlbLat, icLat, cbLat;
  logic fetchEn;
  logic [1:0] stallReason;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  // bench model state
  logic mBlocked, mUnk;
  int mDelay, mSlot, mBr;

  always #4 clk = ~clk;

  fetch_miss_stall #(
    .LAT_W(LAT_W), .FETCH_SPEED(SPEED), .FETCH_WIDTH(WIDTH), .IC_HIT_LAT(IC_HIT)
  ) u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid),
    .tlbStatus(tlbStatus), .tlbLat(tlbLat),
    .icStatus(icStatus), .icLat(icLat),
    .sameLineHit(sameLineHit), .multiLineEn(multiLineEn),
    .takenBr(takenBr), .unkTgtIn(unkTgtIn), .recover(recover),
    .trapPend(trapPend), .syscallPend(syscallPend),
    .cbValid(cbValid), .cbLat(cbLat),
    .fetchEn(fetchEn), .stallReason(stallReason)
  );

  task automatic setIdle();
    accValid = 0; tlbStatus = 0; tlbLat = 1; icStatus = 0; icLat = 1;
    sameLineHit = 1; multiLineEn = 0; takenBr = 0; unkTgtIn = 0;
    recover = 0; trapPend = 0; syscallPend = 0; cbValid = 0; cbLat = 0;
  endtask

  task automatic hitAccess();
    setIdle();
    accValid = 1;
  endtask

  // expected outputs and next state from the requirements
  task automatic modelStep(output logic en, output logic [1:0] rsn, output string tag);
    logic tMiss, cMiss, grpRst;
    logic nBlocked, nUnk;
    int nDelay, nSlot, nBr;
    en = 0; rsn = 0; tag = "R13"; grpRst = 0;
    nBlocked = mBlocked; nUnk = mUnk; nDelay = mDelay; nSlot = mSlot; nBr = mBr;
    tMiss = (int'(tlbLat) > 1) || (tlbStatus != 0);
    cMiss = (int'(icLat) > IC_HIT) || (icStatus != 0);
    if (mBlocked) begin
      rsn = 1; tag = cbValid ? "R6" : "R4";
    end else if (mDelay != 0) begin
      rsn = 1; tag = "R7"; nDelay = mDelay - 1;
    end else if (trapPend || syscallPend) begin
      rsn = 3; tag = "R11"; grpRst = 1;
    end else if (mUnk && !recover) begin
      rsn = 3; tag = "R10"; grpRst = 1;
    end else if (mBr >= SPEED) begin
      rsn = 3; tag = "R9"; grpRst = 1;
    end else if (mSlot >= WIDTH) begin
      rsn = 3; tag = "R12"; grpRst = 1;
    end else if (accValid) begin
      if (mSlot != 0 && !multiLineEn && !sameLineHit) begin
        rsn = 2; tag = "R8"; grpRst = 1;
      end else if (tMiss) begin
        rsn = 1; grpRst = 1;
        if (tlbStatus == 0) begin tag = "R2"; nDelay = int'(tlbLat) - 1; end
        else if (tlbStatus == 1) begin tag = "R4"; nBlocked = 1; end
        else tag = "R5";
      end else if (cMiss) begin
        rsn = 1; grpRst = 1;
        if (icStatus == 0) begin tag = "R3"; nDelay = int'(icLat) - 1; end
        else if (icStatus == 1) begin tag = "R4"; nBlocked = 1; end
        else tag = "R5";
      end else begin
        en = 1; nSlot = mSlot + 1; nBr = mBr + int'(takenBr);
        if (unkTgtIn) nUnk = 1;
      end
    end
    if (grpRst) begin nSlot = 0; nBr = 0; end
    if (cbValid) begin nBlocked = 0; nDelay = int'(cbLat); end
    if (recover) begin nUnk = 0; nSlot = 0; nBr = 0; end
    mBlocked = nBlocked; mUnk = nUnk; mDelay = nDelay; mSlot = nSlot; mBr = nBr;
  endtask

  // inputs already set; check before the edge, advance to next drive point
  task automatic stepCheck();
    logic en; logic [1:0] rsn; string tag;
    #2;
    modelStep(en, rsn, tag);
    nTests++;
    if (fetchEn !== en || stallReason !== rsn) begin
      nFail++;
      $display("FAIL %s: fetchEn=%0b stallReason=%0d expected fetchEn=%0b stallReason=%0d at %0t",
               tag, fetchEn, stallReason, en, rsn, $time);
    end
    @(negedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog: expired, expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5eed_0413));
    setIdle();
    rstN = 0;
    mBlocked = 0; mUnk = 0; mDelay = 0; mSlot = 0; mBr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1: reset state, idle then first hit accepted
    setIdle(); stepCheck();
    hitAccess(); stepCheck();
    // R2: known translation miss, latency 4 -> three stall cycles
    hitAccess(); tlbLat = 4; stepCheck();
    for (int i = 0; i < 3; i++) begin setIdle(); stepCheck(); end
    hitAccess(); stepCheck();
    // R3: cache known miss latency 5 behind a translation hit
    hitAccess(); icLat = 5; stepCheck();
    for (int i = 0; i < 5; i++) begin hitAccess(); stepCheck(); end
    // R3: translation miss hides a cache miss
    hitAccess(); tlbStatus = 2; icStatus = 1; stepCheck();
    hitAccess(); stepCheck();
    // R4/R6: unknown cache miss, callback later with latency 2
    hitAccess(); icStatus = 1; stepCheck();
    for (int i = 0; i < 3; i++) begin hitAccess(); stepCheck(); end
    hitAccess(); cbValid = 1; cbLat = 2; stepCheck();
    for (int i = 0; i < 3; i++) begin hitAccess(); stepCheck(); end
    // R6: callback with zero latency
    hitAccess(); tlbStatus = 1; stepCheck();
    setIdle(); cbValid = 1; cbLat = 0; stepCheck();
    hitAccess(); stepCheck();
    // R5: retry leaves nothing behind
    hitAccess(); icStatus = 2; stepCheck();
    hitAccess(); stepCheck();
    // R8: line end without multi-line, then with it
    hitAccess(); sameLineHit = 0; stepCheck();
    hitAccess(); sameLineHit = 0; stepCheck();
    hitAccess(); stepCheck();
    hitAccess(); sameLineHit = 0; multiLineEn = 1; stepCheck();
    // R9: two taken branches end the group
    setIdle(); recover = 1; stepCheck();
    hitAccess(); takenBr = 1; stepCheck();
    hitAccess(); takenBr = 1; stepCheck();
    hitAccess(); stepCheck();
    hitAccess(); stepCheck();
    // R10: unknown target holds stop until recovery
    hitAccess(); unkTgtIn = 1; stepCheck();
    hitAccess(); stepCheck();
    hitAccess(); stepCheck();
    hitAccess(); recover = 1; stepCheck();
    hitAccess(); stepCheck();
    // R11: trap and syscall pending
    hitAccess(); trapPend = 1; stepCheck();
    hitAccess(); syscallPend = 1; stepCheck();
    // R12: width reached
    setIdle(); recover = 1; stepCheck();
    for (int i = 0; i < WIDTH + 2; i++) begin hitAccess(); stepCheck(); end
    // R13: priority, countdown beats trap
    hitAccess(); tlbLat = 3; stepCheck();
    hitAccess(); trapPend = 1; stepCheck();
    // random mix
    for (int n = 0; n < 4000; n++) begin
      setIdle();
      accValid    = ($urandom_range(0, 9) < 7);
      tlbStatus   = ($urandom_range(0, 19) == 0) ? 2'($urandom_range(0, 3)) : 2'd0;
      tlbLat      = ($urandom_range(0, 9) == 0) ? LAT_W'($urandom_range(0, 6)) : LAT_W'(1);
      icStatus    = ($urandom_range(0, 14) == 0) ? 2'($urandom_range(0, 3)) : 2'd0;
      icLat       = ($urandom_range(0, 7) == 0) ? LAT_W'($urandom_range(0, 7)) : LAT_W'(IC_HIT);
      sameLineHit = ($urandom_range(0, 4) != 0);
      multiLineEn = ($urandom_range(0, 3) == 0);
      takenBr     = ($urandom_range(0, 3) == 0);
      unkTgtIn    = ($urandom_range(0, 24) == 0);
      recover     = ($urandom_range(0, 9) == 0);
      trapPend    = ($urandom_range(0, 39) == 0);
      syscallPend = ($urandom_range(0, 39) == 0);
      if (mBlocked && $urandom_range(0, 3) == 0) begin
        cbValid = 1;
        cbLat   = LAT_W'($urandom_range(0, 5));
      end
      stepCheck();
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule